// File: doc/BRIEF.md
# Multi-Source Reset Output Generator

This block drives a chip's active-low reset output and records why the core was last reset. Five causes can ask for reset: power-on, an external reset pin, a watchdog timeout strobe, an oscillator-fail detect and a power-fail detect. Each cause has its own stretch length. Power-on, oscillator-fail and power-fail hold the output low for a long fixed count of clocks. A watchdog timeout holds it for exactly two machine cycles. The external pin is followed closely, with a short synchroniser delay.

All requests feed one down-counter. The output is low while that counter is non-zero. When a request arrives during a running pulse, the counter keeps whichever is larger: the time still left, or the new request's full length. A sticky cause register captures every request that fires. Software clears its bits with a write-one-to-clear strobe.

Every pin here is a plain control or status level. No data stream flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `rst_out_gen`

## Requirements
- R1: `rst_n_o` is low whenever the internal stretch count is non-zero. It is high once every request has expired. Cause bit positions are: 0 power-on, 1 external pin, 2 watchdog, 3 oscillator fail, 4 power fail.
- R2: On a clock edge where `osc_fail_i` or `pwr_fail_i` is sampled high, the output goes low from that edge on. It stays low until LONG_CLKS clocks after the last edge on which the request was sampled high. A one-clock request therefore gives a pulse of LONG_CLKS clocks (default 65536).
- R3: A watchdog strobe sampled high drives the output low from the next clock for exactly 2*MC_CLKS clocks (default MC_CLKS = 4, so 8 clocks).
- R4: `ext_rst_i` passes through a two-flop synchroniser. The output goes low 3 clocks after the pin is first sampled high and rises 3 clocks after the pin is first sampled low. The low time therefore equals the number of clocks the pin was sampled high, and the added delay stays under 1.25 machine cycles.
- R5: While `por_n_i` is low, the output is low. After `por_n_i` is released, the output rises on the LONG_CLKS-th rising clock edge.
- R6: A request that arrives during a running pulse sets the remaining time to the larger of the time left and that request's full length.
- R7: Each request that fires sets its cause bit. After power-on, the cause register reads 5'b00001.
- R8: A 1 in `cause_clr_i` clears that cause bit on the next edge. If a set for the same bit happens on the same edge, the set wins.
- R9: A clear strobe has no effect on bits whose strobe bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n_i | input | 1 | Power-on indication, active low, asynchronous |
| ext_rst_i | input | 1 | External reset pin, active high, asynchronous |
| wdt_to_i | input | 1 | Watchdog timeout strobe, synchronous |
| osc_fail_i | input | 1 | Oscillator-fail detect, synchronous level |
| pwr_fail_i | input | 1 | Power-fail detect, synchronous level |
| cause_clr_i | input | 5 | Write-one-to-clear strobe for the cause bits |
| rst_n_o | output | 1 | Active-low reset output |
| cause_o | output | 5 | Sticky reset-cause register |

## Verification
A synchronous request sampled on an edge pulls the output low right after that edge, so the output is read at the following falling edge. The external pin shows up on the output only after three edges: two synchroniser flops and then the counter load. A cause bit or a clear takes effect one edge after its strobe. The bench drives every input on falling edges and samples outputs on falling edges. A scoreboard queue holds the expected low length of each pulse. The monitor counts low falling-edge samples and, when the output rises, compares that count with the queue entry. Pulse lengths are therefore checked exactly, whatever the overlap pattern.

// File: rtl/rst_out_pkg.sv
package rst_out_pkg;
  localparam int NSRC    = 5;
  localparam int SRC_POR = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_WDT = 2;
  localparam int SRC_OSC = 3;
  localparam int SRC_PWR = 4;
endpackage

// File: rtl/rst_out_sync.sv
module rst_out_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rst_out_merge.sv
module rst_out_merge
  import rst_out_pkg::*;
#(
  parameter int CNT_W     = 17,
  parameter int LONG_CLKS = 65536,
  parameter int MC_CLKS   = 4
) (
  input  logic [NSRC-1:0]  req,
  output logic [CNT_W-1:0] dur
);
  localparam logic [CNT_W-1:0] LONG_D = CNT_W'(LONG_CLKS);
  localparam logic [CNT_W-1:0] WDT_D  = CNT_W'(2 * MC_CLKS);
  localparam logic [CNT_W-1:0] EXT_D  = CNT_W'(1);

  function automatic logic [CNT_W-1:0] len_of(input int idx);
    case (idx)
      SRC_EXT: len_of = EXT_D;
      SRC_WDT: len_of = WDT_D;
      SRC_OSC, SRC_PWR, SRC_POR: len_of = LONG_D;
      default: len_of = '0;
    endcase
  endfunction

  logic [CNT_W-1:0] cand [NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_cand
    assign cand[i] = req[i] ? len_of(i) : '0;
  end

  always_comb begin
    dur = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] > dur) dur = cand[i];
    end
  end
endmodule

// File: rtl/rst_out_stretch.sv
module rst_out_stretch #(
  parameter int CNT_W     = 17,
  parameter int LONG_CLKS = 65536
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [CNT_W-1:0] load_dur,
  output logic             active
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    dec = (cnt != '0) ? cnt - 1'b1 : '0;
    nxt = (load_dur > dec) ? load_dur : dec;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt <= CNT_W'(LONG_CLKS);
    else         cnt <= nxt;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/rst_out_cause.sv
module rst_out_cause #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] cause
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic RST_VAL = (i == 0);
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     cause[i] <= RST_VAL;
      else if (set[i]) cause[i] <= 1'b1;
      else if (clr[i]) cause[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_out_gen.sv
module rst_out_gen
  import rst_out_pkg::*;
#(
  parameter int MC_CLKS     = 4,
  parameter int LONG_CLKS   = 65536,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            por_n_i,
  input  logic            ext_rst_i,
  input  logic            wdt_to_i,
  input  logic            osc_fail_i,
  input  logic            pwr_fail_i,
  input  logic [NSRC-1:0] cause_clr_i,
  output logic            rst_n_o,
  output logic [NSRC-1:0] cause_o
);
  localparam int CNT_W = $clog2(LONG_CLKS + 1);

  logic            ext_s;
  logic [NSRC-1:0] req;
  logic [CNT_W-1:0] dur;
  logic            active;

  rst_out_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(por_n_i), .d(ext_rst_i), .q(ext_s)
  );

  always_comb begin
    req          = '0;
    req[SRC_EXT] = ext_s;
    req[SRC_WDT] = wdt_to_i;
    req[SRC_OSC] = osc_fail_i;
    req[SRC_PWR] = pwr_fail_i;
  end

  rst_out_merge #(.CNT_W(CNT_W), .LONG_CLKS(LONG_CLKS), .MC_CLKS(MC_CLKS)) u_merge (
    .req(req), .dur(dur)
  );

  rst_out_stretch #(.CNT_W(CNT_W), .LONG_CLKS(LONG_CLKS)) u_stretch (
    .clk(clk), .arst_n(por_n_i), .load_dur(dur), .active(active)
  );

  rst_out_cause #(.W(NSRC)) u_cause (
    .clk(clk), .arst_n(por_n_i), .set(req), .clr(cause_clr_i), .cause(cause_o)
  );

  assign rst_n_o = ~active;
endmodule

// File: rtl/rst_out_gen_chk.sv
module rst_out_gen_chk
  import rst_out_pkg::*;
(
  input logic            clk,
  input logic            por_n_i,
  input logic            ext_rst_i,
  input logic            wdt_to_i,
  input logic            osc_fail_i,
  input logic            pwr_fail_i,
  input logic [NSRC-1:0] cause_clr_i,
  input logic            rst_n_o,
  input logic [NSRC-1:0] cause_o
);
  // R2
  osc_low_chk: assert property (@(posedge clk) disable iff (!por_n_i)
    osc_fail_i |=> !rst_n_o);

  // R2
  pwr_low_chk: assert property (@(posedge clk) disable iff (!por_n_i)
    pwr_fail_i |=> !rst_n_o);

  // R3
  wdt_low_chk: assert property (@(posedge clk) disable iff (!por_n_i)
    wdt_to_i |=> !rst_n_o);

  // R4
  ext_low_chk: assert property (@(posedge clk) disable iff (!por_n_i)
    (ext_rst_i && $past(ext_rst_i) && $past(ext_rst_i, 2)) |=> !rst_n_o);

  // R7
  wdt_cause_chk: assert property (@(posedge clk) disable iff (!por_n_i)
    wdt_to_i |=> cause_o[SRC_WDT]);

  // R8
  wdt_clr_chk: assert property (@(posedge clk) disable iff (!por_n_i)
    (cause_clr_i[SRC_WDT] && !wdt_to_i) |=> !cause_o[SRC_WDT]);
endmodule

bind rst_out_gen rst_out_gen_chk chk_i (.*);

// File: tb/rst_out_gen_tb_top.sv
`timescale 1ns/100ps
module rst_out_gen_tb_top;
  localparam int MC   = 4;
  localparam int LONG = 200;

  logic       clk = 1'b0;
  logic       por_n_i = 1'b0;
  logic       ext_rst_i = 1'b0;
  logic       wdt_to_i = 1'b0;
  logic       osc_fail_i = 1'b0;
  logic       pwr_fail_i = 1'b0;
  logic [4:0] cause_clr_i = '0;
  logic       rst_n_o;
  logic [4:0] cause_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  rst_out_gen #(.MC_CLKS(MC), .LONG_CLKS(LONG)) dut_i (
    .clk(clk), .por_n_i(por_n_i), .ext_rst_i(ext_rst_i), .wdt_to_i(wdt_to_i),
    .osc_fail_i(osc_fail_i), .pwr_fail_i(pwr_fail_i), .cause_clr_i(cause_clr_i),
    .rst_n_o(rst_n_o), .cause_o(cause_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int len, input string tag);
    exp_q.push_back(len);
    tag_q.push_back(tag);
  endtask

  // monitor: counts low samples, pops an expected length at each rise
  int low_cnt = 0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (!rst_n_o) low_cnt++;
      else if (low_cnt > 0) begin
        if (exp_q.size() == 0) check("R1 unexpected pulse", low_cnt, 0);
        else check(tag_q.pop_front(), low_cnt, exp_q.pop_front());
        low_cnt = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_idle();
    while (exp_q.size() != 0 || !rst_n_o || low_cnt != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_all();
    cause_clr_i = 5'h1f;
    @(negedge clk);
    cause_clr_i = '0;
  endtask

  task automatic hold(ref logic sig, input int n);
    sig = 1'b1;
    repeat (n) @(negedge clk);
    sig = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R5 R7: reset state
    check("R5 low during power-on", rst_n_o, 0);
    check("R7 cause after power-on", cause_o, 5'b00001);
    por_n_i = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!rst_n_o && n < 1000);
    check("R5 release edge", n, LONG);
    mon_en = 1'b1;

    clear_all();
    check("R8 clear all", cause_o, 0);

    // R4: pin held 2 clocks, then 7 clocks; rise 3 clocks after pin drop
    push(2, "R4 ext length 2");
    hold(ext_rst_i, 2);
    n = 0;
    do begin @(negedge clk); n++; end while (!rst_n_o && n < 20);
    check("R4 rise delay after pin", n, 3);
    wait_idle();
    push(7, "R4 ext length 7");
    hold(ext_rst_i, 7);
    wait_idle();
    check("R7 ext cause bit1", cause_o, 5'b00010);
    clear_all();

    // R3
    push(2 * MC, "R3 watchdog length");
    hold(wdt_to_i, 1);
    check("R3 low next clock", rst_n_o, 0);
    wait_idle();
    check("R7 wdt cause bit2", cause_o, 5'b00100);
    // R9: clearing other bits leaves bit2
    cause_clr_i = 5'b11011;
    @(negedge clk);
    cause_clr_i = '0;
    check("R9 unrelated clear", cause_o, 5'b00100);
    clear_all();

    // R2
    push(LONG, "R2 osc length");
    hold(osc_fail_i, 1);
    wait_idle();
    check("R7 osc cause bit3", cause_o, 5'b01000);
    clear_all();
    push(LONG + 4, "R2 pwr length 5-clock request");
    hold(pwr_fail_i, 5);
    wait_idle();
    check("R7 pwr cause bit4", cause_o, 5'b10000);
    clear_all();

    // R6: overlaps
    push(3 + LONG, "R6 wdt then osc");
    hold(wdt_to_i, 1);
    repeat (2) @(negedge clk);
    hold(osc_fail_i, 1);
    wait_idle();
    push(LONG, "R6 osc then wdt");
    hold(osc_fail_i, 1);
    repeat (9) @(negedge clk);
    hold(wdt_to_i, 1);
    wait_idle();
    push(5 + 2 * MC, "R6 wdt twice");
    hold(wdt_to_i, 1);
    repeat (4) @(negedge clk);
    hold(wdt_to_i, 1);
    wait_idle();
    clear_all();

    // R8: set wins over clear
    wdt_to_i = 1'b1;
    cause_clr_i = 5'b00100;
    push(2 * MC, "R1 wdt with clear");
    @(negedge clk);
    wdt_to_i = 1'b0;
    cause_clr_i = '0;
    check("R8 set beats clear", cause_o, 5'b00100);
    wait_idle();
    check("R1 output high when idle", rst_n_o, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule